// File: doc/BRIEF.md
# Single-Line Bus Master Slot Sequencer

This block drives the timed waveforms of a standard-speed 1-Wire bus from the master side. It has an open-drain style pulldown output and a line-sense input. A host logic block picks one of four operations: a bus reset with presence detection, a write of a 0 bit, a write of a 1 bit, or a read slot. The host then pulses a start strobe. The sequencer holds `busy` high until the operation is complete and the required recovery high time has passed, so the next operation cannot begin too early.

All durations are whole microsecond ticks and are set by parameters. An internal prescaler builds each tick from `TICK_DIV` clock cycles and restarts when an operation is accepted. Elaboration-time checks reject a timing set that breaks the bus rules: reset low between 480 and 960 µs, presence sampled 60 to 75 µs after release, write-0 low between 60 and 120 µs, short pulses under 15 µs, read sampling inside the 15 µs window, slots of at least 61 µs, and at least 1 µs of recovery. A reset returns a presence flag. A read returns the sampled bit. Both results are held until the same kind of operation runs again.

Top module: `ow_slot_engine`

## Requirements
- R1: After reset, `busy`, `pull_low`, `done`, `presence` and `rd_bit` are all 0.
- R2: With `cmd` = 2'b00 (bus reset) accepted, `pull_low` is high for RST_LOW ticks (RST_LOW×TICK_DIV clock cycles) from the accepting edge, then released.
- R3: For a bus reset, the line is sampled RST_LOW+PRES_SAMPLE ticks after acceptance. `presence` becomes 1 if the line was low and 0 if it was high. `busy` stays high for RST_LOW+RST_HIGH ticks.
- R4: With `cmd` = 2'b01 (write 0), `pull_low` is high for W0_LOW ticks. With `cmd` = 2'b10 (write 1), it is high for W1_LOW ticks.
- R5: With `cmd` = 2'b11 (read), `pull_low` is high for RD_LOW ticks. The line is sampled RD_SAMPLE ticks after acceptance and the value is held on `rd_bit`.
- R6: Each of the three slot operations keeps `busy` high for SLOT_LEN+REC_LEN ticks. `pull_low` is released at least one tick before `busy` falls.
- R7: `done` is a one-cycle pulse in the first cycle in which `busy` is low after an operation.
- R8: A start strobe while `busy` is high is ignored. The running operation keeps its command and duration, and no extra operation follows.
- R9: `pull_low` is never high while `busy` is low.
- R10: One tick equals TICK_DIV clock cycles. The tick count restarts at the accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, accepted only while idle |
| cmd | input | 2 | Operation: 00 reset, 01 write 0, 10 write 1, 11 read |
| line_in | input | 1 | Synchronised level of the bus line |
| busy | output | 1 | Operation or recovery in progress |
| done | output | 1 | One-cycle completion pulse |
| pull_low | output | 1 | Drive the bus low when 1; release when 0 |
| presence | output | 1 | Result of the last bus reset |
| rd_bit | output | 1 | Bit sampled by the last read slot |

## Verification
The assertions assume that `line_in` is already synchronised to `clk` and that `start` and `cmd` change only between clock edges. The bench drives every input on the falling edge. It builds `line_in` as a wired-AND of the block's own pulldown and an emulated slave pulldown. The slave pulls low only inside the presence window or during the first part of a read slot, so the sampled level is stable around each sampling edge. Start strobes are applied both from idle and in the middle of a running slot, and again on the completion cycle.

// File: rtl/ow_pkg.sv
package ow_pkg;
   typedef enum logic [1:0] {
      OW_RESET = 2'b00,
      OW_WR0   = 2'b01,
      OW_WR1   = 2'b10,
      OW_READ  = 2'b11
   } ow_cmd_e;
endpackage

// File: rtl/ow_tick_gen.sv
module ow_tick_gen #(
   parameter int TICK_DIV = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   output logic tick
);
   generate
      if (TICK_DIV == 1) begin : g_direct
         assign tick = en;
      end else begin : g_presc
         localparam int PW = $clog2(TICK_DIV);
         localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
         logic [PW-1:0] presc;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        presc <= '0;
            else if (clr)      presc <= '0;
            else if (en)       presc <= (presc == LAST) ? '0 : presc + PW'(1);
         end
         assign tick = en && (presc == LAST);
      end
   endgenerate
endmodule

// File: rtl/ow_seq.sv
module ow_seq
   import ow_pkg::*;
#(
   parameter int RST_LOW     = 480,
   parameter int PRES_SAMPLE = 70,
   parameter int RST_HIGH    = 480,
   parameter int W0_LOW      = 65,
   parameter int W1_LOW      = 6,
   parameter int RD_LOW      = 6,
   parameter int RD_SAMPLE   = 12,
   parameter int SLOT_LEN    = 70,
   parameter int REC_LEN     = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic [1:0] cmd,
   input  logic line_in,
   input  logic tick,
   output logic accept,
   output logic busy,
   output logic done,
   output logic pull_low,
   output logic presence,
   output logic rd_bit
);
   localparam int RST_END  = RST_LOW + RST_HIGH;
   localparam int SLOT_END = SLOT_LEN + REC_LEN;
   localparam int MAX_END  = (RST_END > SLOT_END) ? RST_END : SLOT_END;
   localparam int CW       = $clog2(MAX_END + 1);

   ow_cmd_e       cmd_q;
   logic [CW-1:0] cnt, cnt_nxt, low_lim, samp_pt, end_pt;
   logic          samp_en;

   assign accept  = start && !busy;
   assign cnt_nxt = cnt + CW'(1);

   always_comb begin
      case (cmd_q)
         OW_RESET: begin
            low_lim = CW'(RST_LOW); samp_pt = CW'(RST_LOW + PRES_SAMPLE);
            samp_en = 1'b1;         end_pt  = CW'(RST_END);
         end
         OW_WR0: begin
            low_lim = CW'(W0_LOW);  samp_pt = '0;
            samp_en = 1'b0;         end_pt  = CW'(SLOT_END);
         end
         OW_WR1: begin
            low_lim = CW'(W1_LOW);  samp_pt = '0;
            samp_en = 1'b0;         end_pt  = CW'(SLOT_END);
         end
         default: begin
            low_lim = CW'(RD_LOW);  samp_pt = CW'(RD_SAMPLE);
            samp_en = 1'b1;         end_pt  = CW'(SLOT_END);
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0; done <= 1'b0; cnt <= '0; cmd_q <= OW_RESET;
         presence <= 1'b0; rd_bit <= 1'b0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            busy  <= 1'b1;
            cnt   <= '0;
            cmd_q <= ow_cmd_e'(cmd);
         end else if (busy && tick) begin
            if (samp_en && cnt_nxt == samp_pt) begin
               if (cmd_q == OW_RESET) presence <= !line_in;
               else                   rd_bit   <= line_in;
            end
            if (cnt_nxt == end_pt) begin
               busy <= 1'b0;
               done <= 1'b1;
               cnt  <= '0;
            end else begin
               cnt <= cnt_nxt;
            end
         end
      end
   end

   assign pull_low = busy && (cnt < low_lim);

   // R9
   idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !pull_low);
   // R7
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));
   // R6
   recovery_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !$past(pull_low));
   // R8
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(cmd_q));
   // R8
   start_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
endmodule

// File: rtl/ow_slot_engine.sv
module ow_slot_engine #(
   parameter int TICK_DIV    = 50,
   parameter int RST_LOW     = 480,
   parameter int PRES_SAMPLE = 70,
   parameter int RST_HIGH    = 480,
   parameter int W0_LOW      = 65,
   parameter int W1_LOW      = 6,
   parameter int RD_LOW      = 6,
   parameter int RD_SAMPLE   = 12,
   parameter int SLOT_LEN    = 70,
   parameter int REC_LEN     = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [1:0] cmd,
   input  logic       line_in,
   output logic       busy,
   output logic       done,
   output logic       pull_low,
   output logic       presence,
   output logic       rd_bit
);
   generate
      if (TICK_DIV < 1) begin : g_bad_div
         $error("TICK_DIV must be at least 1");
      end
      if (RST_LOW < 480 || RST_LOW > 960) begin : g_bad_rst_low
         $error("reset low time out of 480..960 us");
      end
      if (PRES_SAMPLE < 60 || PRES_SAMPLE > 75 || RST_HIGH < 480 || PRES_SAMPLE >= RST_HIGH) begin : g_bad_pres
         $error("presence sample or reset high time illegal");
      end
      if (W0_LOW < 60 || W0_LOW > 120 || W0_LOW >= SLOT_LEN) begin : g_bad_w0
         $error("write-0 low time illegal");
      end
      if (W1_LOW < 1 || W1_LOW > 14 || RD_LOW < 1 || RD_LOW > 14) begin : g_bad_short
         $error("short low pulse must be 1..14 us");
      end
      if (RD_SAMPLE <= RD_LOW || RD_SAMPLE > 15) begin : g_bad_rd_samp
         $error("read sample point must follow release and be within 15 us");
      end
      if (SLOT_LEN < 61 || REC_LEN < 1) begin : g_bad_slot
         $error("slot under 61 us or no recovery");
      end
   endgenerate

   logic accept, tick;

   ow_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .clr(accept), .en(busy), .tick(tick)
   );

   ow_seq #(
      .RST_LOW(RST_LOW), .PRES_SAMPLE(PRES_SAMPLE), .RST_HIGH(RST_HIGH),
      .W0_LOW(W0_LOW), .W1_LOW(W1_LOW), .RD_LOW(RD_LOW),
      .RD_SAMPLE(RD_SAMPLE), .SLOT_LEN(SLOT_LEN), .REC_LEN(REC_LEN)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .line_in(line_in),
      .tick(tick), .accept(accept), .busy(busy), .done(done),
      .pull_low(pull_low), .presence(presence), .rd_bit(rd_bit)
   );
endmodule

// File: tb/tb_ow_slot_engine.sv
module tb_ow_slot_engine;
   localparam int D = 2;
   localparam int T_RL = 480, T_PS = 70, T_RH = 480, T_W0 = 65, T_W1 = 6;
   localparam int T_RDL = 6, T_RDS = 12, T_SL = 70, T_REC = 2;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, line_in;
   logic [1:0] cmd = 2'b00;
   logic busy, done, pull_low, presence, rd_bit;
   logic slave_low = 1'b0;

   always #10 clk = ~clk;
   assign line_in = !(pull_low || slave_low);

   ow_slot_engine #(.TICK_DIV(D)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .line_in(line_in),
      .busy(busy), .done(done), .pull_low(pull_low),
      .presence(presence), .rd_bit(rd_bit)
   );

   int vectors = 0, errors = 0, slave_mode = 0;
   int cnt_pull = 0, cnt_busy = 0, cnt_done = 0;
   bit finished = 0;
   bit mbusy = 0, mdone = 0, mpres = 0, mbit = 0;
   int mk = 0, mcmd = 0;

   function automatic int low_of(int c);
      case (c) 0: return T_RL; 1: return T_W0; 2: return T_W1; default: return T_RDL; endcase
   endfunction
   function automatic int end_of(int c);
      return (c == 0) ? T_RL + T_RH : T_SL + T_REC;
   endfunction

   task automatic chk(bit ok, string tag, int act, int exp);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step(bit st, int c);
      bit ep, ln;
      @(negedge clk);
      ep = mbusy && (mk / D < low_of(mcmd));
      chk(busy == mbusy, "R6 busy", busy, mbusy);
      chk(pull_low == ep, mbusy ? "R2/R4/R5 pull_low" : "R9 pull_low", pull_low, ep);
      chk(done == mdone, "R7 done", done, mdone);
      chk(presence == mpres, "R3 presence", presence, mpres);
      chk(rd_bit == mbit, "R5 rd_bit", rd_bit, mbit);
      cnt_pull += pull_low; cnt_busy += busy; cnt_done += done;
      start = st; cmd = 2'(c);
      slave_low = (slave_mode == 1 && mbusy && mcmd == 0 &&
                   mk >= (T_RL + 20) * D && mk < (T_RL + 150) * D) ||
                  (slave_mode == 2 && mbusy && mcmd == 3 && mk < 30 * D);
      ln = !(ep || slave_low);
      if (mbusy) begin
         mdone = 0;
         mk++;
         if (mcmd == 0 && mk == (T_RL + T_PS) * D) mpres = !ln;
         if (mcmd == 3 && mk == T_RDS * D) mbit = ln;
         if (mk == end_of(mcmd) * D) begin mbusy = 0; mdone = 1; end
      end else begin
         mdone = 0;
         if (st) begin mbusy = 1; mk = 0; mcmd = c; end
      end
   endtask

   task automatic run(int c, int mode, int exp_pull, int exp_busy, string tag);
      slave_mode = mode;
      cnt_pull = 0; cnt_busy = 0; cnt_done = 0;
      step(1, c);
      while (mbusy) step(0, c);
      step(0, c); step(0, c);
      chk(cnt_pull == exp_pull, {tag, " low cycles"}, cnt_pull, exp_pull);
      chk(cnt_busy == exp_busy, {tag, " busy cycles"}, cnt_busy, exp_busy);
      chk(cnt_done == 1, "R7 done pulses", cnt_done, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1
      chk(!busy && !pull_low && !done && !presence && !rd_bit, "R1 reset state",
          {busy, pull_low, done, presence, rd_bit}, 0);
      rst_n = 1'b1;
      step(0, 0); step(0, 0);
      // R10 R2 R3: reset with a slave answering
      run(0, 1, T_RL * D, (T_RL + T_RH) * D, "R2 R10");
      chk(presence == 1, "R3 presence seen", presence, 1);
      run(0, 0, T_RL * D, (T_RL + T_RH) * D, "R3");
      chk(presence == 0, "R3 no presence", presence, 0);
      // R4
      run(1, 0, T_W0 * D, (T_SL + T_REC) * D, "R4 write0");
      run(2, 0, T_W1 * D, (T_SL + T_REC) * D, "R4 write1");
      // R5
      run(3, 2, T_RDL * D, (T_SL + T_REC) * D, "R5 read0");
      chk(rd_bit == 0, "R5 read zero", rd_bit, 0);
      run(3, 0, T_RDL * D, (T_SL + T_REC) * D, "R5 read1");
      chk(rd_bit == 1, "R5 read one", rd_bit, 1);
      // R8: start held high mid-slot with another command
      slave_mode = 0; cnt_pull = 0; cnt_busy = 0; cnt_done = 0;
      step(1, 2);
      for (int i = 0; i < 40; i++) step(1, 1);
      while (mbusy) step(0, 1);
      step(0, 1); step(0, 1); step(0, 1);
      chk(cnt_pull == T_W1 * D, "R8 ignored start low cycles", cnt_pull, T_W1 * D);
      chk(cnt_busy == (T_SL + T_REC) * D, "R8 ignored start busy", cnt_busy, (T_SL + T_REC) * D);
      chk(cnt_done == 1, "R8 single op", cnt_done, 1);
      // R7: start on the done cycle
      step(1, 3);
      while (!mdone) step(0, 3);
      step(1, 1);
      while (mbusy) step(0, 1);
      step(0, 0);
      chk(!busy && !pull_low, "R9 idle after back-to-back", {busy, pull_low}, 0);
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end
endmodule